// File: doc/BRIEF.md
# System Control Register Bank

A memory-mapped block of 32-bit control and status words for a small SoC. It decodes a 4 KiB byte window on a plain synchronous register bus: one word address, a write strobe with write data, and a read strobe with registered read data. Any word in the window can be written and read back. The word index is the byte address shifted right by two, so the two lowest address bits play no part.

One word is also a command port. A write there stores the value as usual. A reset or power-off code in that value also raises a one-clock request pulse on a dedicated output, which goes to the chip's reset and power logic. Three status words always read back with bits 29 and 28 set, whatever is stored in them. After reset, four words next to one another hold fixed identification and status defaults, and every other word holds zero.

Top module: `scr_bank`

## Requirements
- R1: After reset, word 0x40 (byte 0x100) holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121, word 0x43 holds 0x05F40121, and every other word holds zero. `rdata_o`, `sys_rst_req_o` and `sys_off_req_o` are zero.
- R2: A write (`we_i` high at a clock edge) stores all 32 bits of `wdata_i` at word `addr_i[11:2]`. A read (`re_i` high at an edge) shows that word on `rdata_o` after that same edge.
- R3: Address bits 1:0 are ignored for both reads and writes.
- R4: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000. The stored word itself is left unchanged.
- R5: A read at byte offset 0x104, and at any offset other than the three in R4, returns the stored word unchanged.
- R6: A write of 1 or 2 to byte offset 0xF00 drives `sys_rst_req_o` high for exactly the one cycle after that write's edge.
- R7: A write of 3 to byte offset 0xF00 drives `sys_off_req_o` high for exactly the one cycle after that write's edge.
- R8: A write of any other value to 0xF00 raises no request. Every write to 0xF00 stores its value, and a read of 0xF00 returns it.
- R9: Writes at any offset other than 0xF00 raise no request, whatever the value.
- R10: `rdata_o` holds its value in every cycle in which `re_i` was low at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address for both reads and writes |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| sys_rst_req_o | output | 1 | System reset request pulse |
| sys_off_req_o | output | 1 | Shutdown request pulse |

## Verification
Every result of this block appears after the edge that samples the strobe. Stored data, read data and both request pulses all change at that edge. The pulses must be gone again after the following edge. The bench drives inputs on the falling edge and samples 1 ns after the rising edge that takes them. After every write it samples once more one edge later to confirm the pulse has ended. It sweeps all 1024 words through reset defaults and a computed pattern, with the low address bits rotated between writes and reads. It also sweeps the command word across the request and non-request codes, and checks that a held read stays stable.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned CMD_BYTE   = 'hF00;
  localparam int unsigned FORCE_B0   = 'h100;
  localparam int unsigned FORCE_B1   = 'h108;
  localparam int unsigned FORCE_B2   = 'h10C;
  localparam logic [31:0] FORCE_BITS = 32'h3000_0000;
  localparam logic [31:0] CODE_RST_A = 32'd1;
  localparam logic [31:0] CODE_RST_B = 32'd2;
  localparam logic [31:0] CODE_OFF   = 32'd3;

  function automatic logic [31:0] reset_word(int unsigned idx);
    case (idx)
      'h40:    return 32'h05F2_0121;
      'h41:    return 32'h0000_0002;
      'h42:    return 32'h05F3_0121;
      'h43:    return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/scr_store.sv
module scr_store #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned WORDS = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rword_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= DATA_W'(scr_pkg::reset_word(g));
      else if (we_i && widx_i == IDX_W'(g))      mem_q[g] <= wdata_i;
    end
  end

  assign rword_o = mem_q[ridx_i];
endmodule

// File: rtl/scr_cmd.sv
module scr_cmd #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rst_req_o,
  output logic              off_req_o
);
  import scr_pkg::*;
  localparam logic [IDX_W-1:0] CMD_IDX = IDX_W'(CMD_BYTE >> 2);

  logic hit, want_rst, want_off;
  assign hit      = we_i && (widx_i == CMD_IDX);
  assign want_rst = hit && (wdata_i == DATA_W'(CODE_RST_A) || wdata_i == DATA_W'(CODE_RST_B));
  assign want_off = hit && (wdata_i == DATA_W'(CODE_OFF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
      off_req_o <= 1'b0;
    end else begin
      rst_req_o <= want_rst;
      off_req_o <= want_off;
    end
  end
endmodule

// File: rtl/scr_rdpath.sv
module scr_rdpath #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  ridx_i,
  input  logic [DATA_W-1:0] rword_i,
  output logic [DATA_W-1:0] rdata_o
);
  import scr_pkg::*;
  localparam logic [IDX_W-1:0] F0 = IDX_W'(FORCE_B0 >> 2);
  localparam logic [IDX_W-1:0] F1 = IDX_W'(FORCE_B1 >> 2);
  localparam logic [IDX_W-1:0] F2 = IDX_W'(FORCE_B2 >> 2);

  logic              forced;
  logic [DATA_W-1:0] rd_val;
  assign forced = (ridx_i == F0) || (ridx_i == F1) || (ridx_i == F2);
  assign rd_val = forced ? (rword_i | DATA_W'(FORCE_BITS)) : rword_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/scr_bank.sv
module scr_bank #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sys_rst_req_o,
  output logic              sys_off_req_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rword;
  logic              unused_lsb;

  assign idx        = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];

  scr_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .we_i,
    .widx_i(idx), .wdata_i, .ridx_i(idx), .rword_o(rword)
  );

  scr_cmd #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_cmd (
    .clk_i, .rst_ni, .we_i,
    .widx_i(idx), .wdata_i,
    .rst_req_o(sys_rst_req_o), .off_req_o(sys_off_req_o)
  );

  scr_rdpath #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni, .re_i,
    .ridx_i(idx), .rword_i(rword), .rdata_o
  );
endmodule

// File: rtl/scr_bank_chk.sv
module scr_bank_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              sys_rst_req_o,
  input logic              sys_off_req_o
);
  import scr_pkg::*;
  logic on_cmd, on_force;
  assign on_cmd   = (addr_i >> 2) == ADDR_W'(CMD_BYTE >> 2);
  assign on_force = (addr_i >> 2) == ADDR_W'(FORCE_B0 >> 2) ||
                    (addr_i >> 2) == ADDR_W'(FORCE_B1 >> 2) ||
                    (addr_i >> 2) == ADDR_W'(FORCE_B2 >> 2);

  AST_RST_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && on_cmd && (wdata_i == DATA_W'(1) || wdata_i == DATA_W'(2))) |=> sys_rst_req_o); // R6
  AST_OFF_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && on_cmd && wdata_i == DATA_W'(3)) |=> sys_off_req_o); // R7
  AST_CMD_OTHER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && on_cmd && wdata_i != DATA_W'(1) && wdata_i != DATA_W'(2) && wdata_i != DATA_W'(3))
      |=> (!sys_rst_req_o && !sys_off_req_o)); // R8
  AST_NO_STRAY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && on_cmd) |=> (!sys_rst_req_o && !sys_off_req_o)); // R9
  AST_FORCED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && on_force) |=> (rdata_o[29:28] == 2'b11)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R10
endmodule

bind scr_bank scr_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_scr_bank.sv
`timescale 1ns/1ps
module tb_scr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic        rreq, oreq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scr_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .sys_rst_req_o(rreq), .sys_off_req_o(oreq)
  );

  function automatic logic [31:0] dflt(int i);
    case (i)
      'h40: return 32'h05F2_0121;
      'h41: return 32'h0000_0002;
      'h42: return 32'h05F3_0121;
      'h43: return 32'h05F4_0121;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] frc(int i);
    return (i == 'h40 || i == 'h42 || i == 'h43) ? 32'h3000_0000 : 32'h0;
  endfunction

  function automatic logic [31:0] pat(int i);
    return (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bit cmd, er, eo;
    string tag;
    cmd = (a >> 2) == 12'h3C0;
    er  = cmd && (d == 1 || d == 2);
    eo  = cmd && (d == 3);
    tag = er ? "R6" : eo ? "R7" : cmd ? "R8" : "R9";
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    chk(rreq == er, {tag, " reset request"}, 32'(rreq), 32'(er));
    chk(oreq == eo, {tag, " shutdown request"}, 32'(oreq), 32'(eo));
    @(negedge clk); we = 1'b0;
    @(posedge clk); #1;
    chk(!rreq && !oreq, {tag, " pulse ends after one cycle"}, {30'b0, rreq, oreq}, 32'h0);
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; re = 1'b1;
    @(posedge clk); #1; v = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, hold;
    #1;
    chk(rdata == 0 && !rreq && !oreq, "R1 outputs in reset", rdata, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1, R4, R5: reset contents across the whole window
    for (int i = 0; i < 1024; i++) begin
      rd(12'(i * 4), v);
      chk(v == (dflt(i) | frc(i)), frc(i) != 0 ? "R1 R4 reset word" : "R1 R5 reset word", v, dflt(i) | frc(i));
    end

    // R2, R3: full sweep, low address bits rotated between write and read
    for (int i = 0; i < 1024; i++) wr(12'(i * 4 + (i % 4)), pat(i));
    for (int i = 0; i < 1024; i++) begin
      rd(12'(i * 4 + ((i + 1) % 4)), v);
      chk(v == (pat(i) | frc(i)), "R2 R3 pattern readback", v, pat(i) | frc(i));
    end

    // R4: forced bits over zero and over set bits; stored value kept
    wr(12'h100, 32'h0);         rd(12'h100, v); chk(v == 32'h3000_0000, "R4 forced over zero", v, 32'h3000_0000);
    wr(12'h108, 32'hCFFF_FFFF); rd(12'h108, v); chk(v == 32'hFFFF_FFFF, "R4 forced over ones", v, 32'hFFFF_FFFF);
    wr(12'h10C, 32'h0000_00A5); rd(12'h10C, v); chk(v == 32'h3000_00A5, "R4 forced low bits", v, 32'h3000_00A5);
    // R5: 0x104 and a neighbour stay raw
    wr(12'h104, 32'h0);         rd(12'h104, v); chk(v == 32'h0, "R5 offset 0x104 unforced", v, 32'h0);
    wr(12'h110, 32'h0);         rd(12'h110, v); chk(v == 32'h0, "R5 offset 0x110 unforced", v, 32'h0);

    // R6, R7, R8: command value sweep, each value stored
    foreach (v[k]) ; // no-op keeps v in scope for clarity
    for (int c = 0; c < 8; c++) begin
      wr(12'hF00, 32'(c)); rd(12'hF01, v);
      chk(v == 32'(c), "R8 command word stores value", v, 32'(c));
    end
    wr(12'hF00, 32'hFFFF_FFFF); rd(12'hF00, v); chk(v == 32'hFFFF_FFFF, "R8 command stores ones", v, 32'hFFFF_FFFF);
    wr(12'hF00, 32'h0000_0101);
    wr(12'hF02, 32'h8000_0001);
    wr(12'hF03, 32'h2);
    wr(12'hF00, 32'h3);

    // R9: request codes at other offsets
    for (int c = 1; c < 4; c++) begin
      wr(12'hF04, 32'(c));
      wr(12'hEFC, 32'(c));
      wr(12'h000, 32'(c));
      wr(12'hB00, 32'(c));
    end

    // R10: read data held while the read strobe is low
    rd(12'h104, hold);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); addr = 12'(k * 4 + 12'h200);
      @(posedge clk); #1;
      chk(rdata == hold, "R10 read data held", rdata, hold);
    end
    wr(12'h104, 32'h1234_5678);
    chk(rdata == hold, "R10 held across a write", rdata, hold);

    // R1: second reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    #1; chk(rdata == 0 && !rreq && !oreq, "R1 outputs cleared by reset", rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(12'h100, v); chk(v == 32'h35F2_0121, "R1 R4 default after reset", v, 32'h35F2_0121);
    rd(12'h104, v); chk(v == 32'h0000_0002, "R1 R5 default after reset", v, 32'h0000_0002);
    rd(12'hF00, v); chk(v == 32'h0, "R1 command word cleared", v, 32'h0);
    rd(12'h200, v); chk(v == 32'h0, "R1 plain word cleared", v, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule